// File: doc/BRIEF.md
# Debug-Mode Entry/Exit Controller

This block is the debug-mode slice of a hart's trap control. It watches the pipeline's retire, ebreak, wfi, dret and exception flags, the current privilege, the dcsr enable bits and an external halt-request line. From these it decides when the core enters or leaves debug mode. On entry it captures the resume PC, the privilege level and the reason for entry. In the same cycle it steers instruction fetch to a configurable park-loop base address. The machine trap CSRs are not touched.

While debug mode is active, the block reports machine mode as the effective privilege and tells the memory-protection unit to bypass its checks. It holds off interrupts, which stay pending, and makes wfi a no-op. Exceptions raised inside debug mode are routed to the park-loop base when an ebreak caused them, and to base + 4 otherwise. A dret leaves debug mode and resumes at the saved PC. Outside debug mode the block also runs the sleep state entered by wfi, which any pending interrupt or a halt request ends.

Top module: `dbg_mode_ctrl`

## Requirements
- R1: An ebreak enters debug mode when the privilege is machine (2'b11) with `ebreakm_i` set, or user (2'b00) with `ebreaku_i` set; cause becomes 1 and `dpc_o` takes `pc_i`. An ebreak without the matching enable causes no entry.
- R2: A rising edge on `halt_req_i` outside debug mode enters with cause 3, and `dpc_o` takes `npc_i`. A request held high causes no further entry after the core leaves debug mode.
- R3: Retiring an instruction while `step_i` is set enters with cause 4, and `dpc_o` takes `npc_i`. Retire with step while already in debug mode has no effect.
- R4: When entry events coincide, ebreak wins over halt edge, and halt edge wins over step.
- R5: In the entry cycle `redirect_o` is 1 with `redirect_pc_o` = DBG_BASE. From the next cycle `dbg_mode_o` is 1 and `prv_o` holds the privilege from the entry cycle.
- R6: In debug mode `eff_priv_o` is 2'b11 and `pmp_bypass_o` is 1. Outside debug mode `eff_priv_o` follows `priv_i` and `pmp_bypass_o` is 0.
- R7: In debug mode an ebreak redirects to DBG_BASE and any other exception redirects to DBG_BASE + 4. Debug mode, `dpc_o`, cause and prv stay unchanged.
- R8: In debug mode and in the entry cycle `irq_take_o` is 0 whatever `irq_pending_i` is. Otherwise it follows `irq_pending_i`.
- R9: wfi outside debug mode sets `sleep_o` from the next cycle. A pending interrupt or a high halt request clears it. In debug mode wfi leaves `sleep_o` at 0.
- R10: dret in debug mode (with no ebreak or exception in the same cycle) redirects to `dpc_o` and clears `dbg_mode_o` on the next cycle. dret outside debug mode raises `illegal_o` and causes no redirect.
- R11: After reset `dbg_mode_o`, `sleep_o`, `dpc_o` and `cause_o` are 0 and `prv_o` is 2'b11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| retire_i | input | 1 | An instruction retires this cycle |
| ebreak_i | input | 1 | An ebreak executes this cycle |
| wfi_i | input | 1 | A wfi executes this cycle |
| dret_i | input | 1 | A dret executes this cycle |
| exc_i | input | 1 | A non-ebreak exception is raised this cycle |
| pc_i | input | XLEN | PC of the current instruction |
| npc_i | input | XLEN | PC of the next instruction |
| priv_i | input | 2 | Current privilege (2'b00 user, 2'b11 machine) |
| halt_req_i | input | 1 | Halt request from the debug module, active high |
| ebreakm_i | input | 1 | dcsr ebreak enable for machine mode |
| ebreaku_i | input | 1 | dcsr ebreak enable for user mode |
| step_i | input | 1 | dcsr single-step enable |
| irq_pending_i | input | 1 | At least one interrupt is pending |
| redirect_o | output | 1 | Fetch must jump to `redirect_pc_o` |
| redirect_pc_o | output | XLEN | Redirect target |
| dbg_mode_o | output | 1 | Core is in debug mode |
| dpc_o | output | XLEN | Saved resume PC |
| cause_o | output | 3 | Entry cause (1 ebreak, 3 halt, 4 step) |
| prv_o | output | 2 | Privilege saved on entry |
| eff_priv_o | output | 2 | Effective privilege |
| pmp_bypass_o | output | 1 | Memory-protection checks are bypassed |
| irq_take_o | output | 1 | A pending interrupt may be taken |
| illegal_o | output | 1 | dret outside debug mode is illegal |
| sleep_o | output | 1 | Core sleeps after wfi |

## Verification
The assertions check several invariants on every cycle. Every entry redirects to the base address and sets the mode flag on the next cycle. The captured privilege matches the entry cycle, dpc never moves while in debug mode, a clean dret always leaves, and sleep is never set inside debug mode. The priority among simultaneous entry events, the edge-only halt behaviour with a held request, and the user/machine ebreak enables are shown by the bench's scenarios. The same holds for the split between base and base + 4 exception targets, interrupts resuming after exit, and the wake of a sleeping core. In all of these the bench's reference model is compared against the outputs on every clock.

// File: rtl/dbg_pkg.sv
package dbg_pkg;
  typedef enum logic [2:0] {
    CAUSE_NONE   = 3'd0,
    CAUSE_EBREAK = 3'd1,
    CAUSE_HALT   = 3'd3,
    CAUSE_STEP   = 3'd4
  } dbg_cause_e;

  localparam logic [1:0] PRIV_U = 2'b00;
  localparam logic [1:0] PRIV_M = 2'b11;
endpackage

// File: rtl/dbg_entry_detect.sv
module dbg_entry_detect
  import dbg_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       dbg_mode_i,
  input  logic       ebreak_i,
  input  logic [1:0] priv_i,
  input  logic       ebreakm_i,
  input  logic       ebreaku_i,
  input  logic       halt_req_i,
  input  logic       retire_i,
  input  logic       step_i,
  output logic       enter_o,
  output dbg_cause_e cause_o
);
  logic halt_prev_q, halt_prev_d;
  logic ebr_hit, halt_edge, step_hit;

  // previous-value flop for the halt request edge
  always_comb halt_prev_d = halt_req_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) halt_prev_q <= 1'b0;
    else         halt_prev_q <= halt_prev_d;
  end

  always_comb begin
    ebr_hit   = ebreak_i & (((priv_i == PRIV_M) & ebreakm_i) |
                            ((priv_i == PRIV_U) & ebreaku_i));
    halt_edge = halt_req_i & ~halt_prev_q;
    step_hit  = retire_i & step_i;
    enter_o   = ~dbg_mode_i & (ebr_hit | halt_edge | step_hit);
    // R4: fixed priority ebreak > halt > step
    if (ebr_hit)        cause_o = CAUSE_EBREAK;
    else if (halt_edge) cause_o = CAUSE_HALT;
    else if (step_hit)  cause_o = CAUSE_STEP;
    else                cause_o = CAUSE_NONE;
  end

  // R2: a request held high across two cycles cannot by itself cause entry
  a_r2_level_no_entry: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (halt_req_i && halt_prev_q && !ebreak_i && !retire_i) |-> !enter_o);
endmodule

// File: rtl/dbg_csr_state.sv
module dbg_csr_state
  import dbg_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            enter_i,
  input  logic            leave_i,
  input  dbg_cause_e      cause_i,
  input  logic [XLEN-1:0] save_pc_i,
  input  logic [1:0]      priv_i,
  output logic            dbg_mode_o,
  output logic [XLEN-1:0] dpc_o,
  output logic [2:0]      cause_o,
  output logic [1:0]      prv_o
);
  logic            mode_q, mode_d;
  logic [XLEN-1:0] dpc_q, dpc_d;
  dbg_cause_e      cause_q, cause_d;
  logic [1:0]      prv_q, prv_d;
  logic            cap_en;

  always_comb begin
    cap_en  = enter_i;
    dpc_d   = save_pc_i;
    cause_d = cause_i;
    prv_d   = priv_i;
    if (enter_i)      mode_d = 1'b1;
    else if (leave_i) mode_d = 1'b0;
    else              mode_d = mode_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) mode_q <= 1'b0;
    else         mode_q <= mode_d;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dpc_q   <= '0;
      cause_q <= CAUSE_NONE;
      prv_q   <= PRIV_M;
    end else if (cap_en) begin
      dpc_q   <= dpc_d;
      cause_q <= cause_d;
      prv_q   <= prv_d;
    end
  end

  assign dbg_mode_o = mode_q;
  assign dpc_o      = dpc_q;
  assign cause_o    = cause_q;
  assign prv_o      = prv_q;

  // R5: captured privilege is the one seen in the entry cycle
  a_r5_prv_capture: assert property (@(posedge clk_i) disable iff (!rst_ni)
    enter_i |=> (prv_o == $past(priv_i)));
  // R7: dpc does not move while debug mode is held
  a_r7_dpc_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_q |=> $stable(dpc_o));
endmodule

// File: rtl/dbg_mode_ctrl.sv
module dbg_mode_ctrl
  import dbg_pkg::*;
#(
  parameter int              XLEN     = 32,
  parameter logic [XLEN-1:0] DBG_BASE = 32'h0000_0800
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            retire_i,
  input  logic            ebreak_i,
  input  logic            wfi_i,
  input  logic            dret_i,
  input  logic            exc_i,
  input  logic [XLEN-1:0] pc_i,
  input  logic [XLEN-1:0] npc_i,
  input  logic [1:0]      priv_i,
  input  logic            halt_req_i,
  input  logic            ebreakm_i,
  input  logic            ebreaku_i,
  input  logic            step_i,
  input  logic            irq_pending_i,
  output logic            redirect_o,
  output logic [XLEN-1:0] redirect_pc_o,
  output logic            dbg_mode_o,
  output logic [XLEN-1:0] dpc_o,
  output logic [2:0]      cause_o,
  output logic [1:0]      prv_o,
  output logic [1:0]      eff_priv_o,
  output logic            pmp_bypass_o,
  output logic            irq_take_o,
  output logic            illegal_o,
  output logic            sleep_o
);
  localparam logic [XLEN-1:0] EXC_ENTRY = DBG_BASE + XLEN'(4);

  logic            enter, leave, dbg_q;
  dbg_cause_e      ent_cause;
  logic [XLEN-1:0] save_pc;
  logic            sleep_q, sleep_d;

  dbg_entry_detect u_detect (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .dbg_mode_i (dbg_q),
    .ebreak_i   (ebreak_i),
    .priv_i     (priv_i),
    .ebreakm_i  (ebreakm_i),
    .ebreaku_i  (ebreaku_i),
    .halt_req_i (halt_req_i),
    .retire_i   (retire_i),
    .step_i     (step_i),
    .enter_o    (enter),
    .cause_o    (ent_cause)
  );

  // synchronous ebreak resumes at itself, interrupt-like entries at the next PC
  assign save_pc = (ent_cause == CAUSE_EBREAK) ? pc_i : npc_i;
  assign leave   = dbg_q & dret_i & ~ebreak_i & ~exc_i;

  dbg_csr_state #(.XLEN(XLEN)) u_state (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .enter_i    (enter),
    .leave_i    (leave),
    .cause_i    (ent_cause),
    .save_pc_i  (save_pc),
    .priv_i     (priv_i),
    .dbg_mode_o (dbg_q),
    .dpc_o      (dpc_o),
    .cause_o    (cause_o),
    .prv_o      (prv_o)
  );

  always_comb begin
    redirect_o    = 1'b0;
    redirect_pc_o = DBG_BASE;
    if (!dbg_q) begin
      redirect_o = enter;
    end else if (ebreak_i) begin
      redirect_o = 1'b1;
    end else if (exc_i) begin
      redirect_o    = 1'b1;
      redirect_pc_o = EXC_ENTRY;
    end else if (dret_i) begin
      redirect_o    = 1'b1;
      redirect_pc_o = dpc_o;
    end
  end

  always_comb begin
    sleep_d = (sleep_q | (wfi_i & ~dbg_q)) & ~(irq_pending_i | halt_req_i) & ~enter;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sleep_q <= 1'b0;
    else         sleep_q <= sleep_d;
  end

  assign dbg_mode_o   = dbg_q;
  assign sleep_o      = sleep_q;
  assign eff_priv_o   = dbg_q ? PRIV_M : priv_i;
  assign pmp_bypass_o = dbg_q;
  assign irq_take_o   = irq_pending_i & ~dbg_q & ~enter;
  assign illegal_o    = dret_i & ~dbg_q;

  // R5: entry redirects to the park loop and sets the mode flag next cycle
  a_r5_enter_redirect: assert property (@(posedge clk_i) disable iff (!rst_ni)
    enter |-> (redirect_o && redirect_pc_o == DBG_BASE));
  a_r5_enter_mode: assert property (@(posedge clk_i) disable iff (!rst_ni)
    enter |=> dbg_mode_o);
  // R10: a clean dret in debug mode always leaves
  a_r10_dret_leaves: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dbg_mode_o && dret_i && !ebreak_i && !exc_i) |=> !dbg_mode_o);
  // R9: the core is never asleep in debug mode
  a_r9_no_sleep_dbg: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dbg_mode_o |-> !sleep_o);
endmodule

// File: tb/dbg_mode_ctrl_bench.sv
module dbg_mode_ctrl_bench;
  localparam int          XLEN = 32;
  localparam logic [31:0] BASE = 32'h0000_0800;
  localparam time         CLK  = 20ns;

  logic clk = 1'b0, rst_n = 1'b0;
  logic retire = 0, ebreak = 0, wfi = 0, dret = 0, exc = 0;
  logic [31:0] pc = 0, npc = 0;
  logic [1:0] priv = 2'b11;
  logic halt = 0, ebm = 0, ebu = 0, step = 0, irq = 0;

  logic        redirect, dbg_mode, pmp_bypass, irq_take, illegal, sleep;
  logic [31:0] redirect_pc, dpc;
  logic [2:0]  cause;
  logic [1:0]  prv, eff_priv;

  int checks = 0, errors = 0;

  // reference model state
  bit          m_dbg = 0, m_hprev = 0, m_sleep = 0;
  logic [31:0] m_dpc = 0;
  logic [2:0]  m_cause = 0;
  logic [1:0]  m_prv = 2'b11;

  always #(CLK/2) clk = ~clk;

  dbg_mode_ctrl #(.XLEN(XLEN), .DBG_BASE(BASE)) u_dbg_mode_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .retire_i(retire), .ebreak_i(ebreak),
    .wfi_i(wfi), .dret_i(dret), .exc_i(exc), .pc_i(pc), .npc_i(npc),
    .priv_i(priv), .halt_req_i(halt), .ebreakm_i(ebm), .ebreaku_i(ebu),
    .step_i(step), .irq_pending_i(irq), .redirect_o(redirect),
    .redirect_pc_o(redirect_pc), .dbg_mode_o(dbg_mode), .dpc_o(dpc),
    .cause_o(cause), .prv_o(prv), .eff_priv_o(eff_priv),
    .pmp_bypass_o(pmp_bypass), .irq_take_o(irq_take), .illegal_o(illegal),
    .sleep_o(sleep)
  );

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // compare one cycle against the model, then advance the model at the edge
  task automatic cyc(string req);
    bit ebr_ok, hedge, stp, ent, x_redir;
    logic [2:0]  ncause;
    logic [31:0] spc, x_rpc;
    #2;
    ebr_ok = ebreak && ((priv == 2'b11 && ebm) || (priv == 2'b00 && ebu));
    hedge  = halt && !m_hprev;
    stp    = retire && step;
    ent    = !m_dbg && (ebr_ok || hedge || stp);
    ncause = ebr_ok ? 3'd1 : (hedge ? 3'd3 : 3'd4);
    spc    = ebr_ok ? pc : npc;
    x_redir = 0; x_rpc = BASE;
    if (!m_dbg) begin
      if (ent) x_redir = 1;
    end else if (ebreak) x_redir = 1;
    else if (exc) begin x_redir = 1; x_rpc = BASE + 4; end
    else if (dret) begin x_redir = 1; x_rpc = m_dpc; end

    chk(req, "redirect", 32'(redirect), 32'(x_redir));
    if (x_redir) chk(req, "redirect_pc", redirect_pc, x_rpc);
    chk(req, "dbg_mode", 32'(dbg_mode), 32'(m_dbg));
    chk(req, "dpc", dpc, m_dpc);
    chk(req, "cause", 32'(cause), 32'(m_cause));
    chk(req, "prv", 32'(prv), 32'(m_prv));
    chk(req, "eff_priv", 32'(eff_priv), m_dbg ? 32'd3 : 32'(priv));
    chk(req, "pmp_bypass", 32'(pmp_bypass), 32'(m_dbg));
    chk(req, "irq_take", 32'(irq_take), 32'(irq && !m_dbg && !ent));
    chk(req, "illegal", 32'(illegal), 32'(dret && !m_dbg));
    chk(req, "sleep", 32'(sleep), 32'(m_sleep));

    @(posedge clk); #1;
    m_hprev = halt;
    if (ent) begin
      m_dbg = 1; m_dpc = spc; m_cause = ncause; m_prv = priv;
    end else if (m_dbg && dret && !ebreak && !exc) m_dbg = 0;
    if (ent || irq || halt) m_sleep = 0;
    else if (wfi && !m_dbg) m_sleep = 1;
    @(negedge clk);
  endtask

  task automatic idle;
    retire = 0; ebreak = 0; wfi = 0; dret = 0; exc = 0;
  endtask

  initial begin
    #(CLK * 100000);
    errors++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R11 reset state
    cyc("R11"); cyc("R11");

    // R1 machine ebreak, enabled
    ebm = 1; priv = 2'b11; pc = 32'h100; npc = 32'h104; ebreak = 1; cyc("R1");
    idle; cyc("R5"); cyc("R6");
    // R7 exceptions inside debug mode
    exc = 1; cyc("R7"); idle;
    ebreak = 1; cyc("R7"); idle;
    // R8 interrupts held off, R9 wfi as no-op
    irq = 1; wfi = 1; cyc("R8"); idle; cyc("R9");
    // R10 leave, interrupt then taken
    dret = 1; cyc("R10"); idle; cyc("R8"); irq = 0;
    // R10 dret outside debug mode
    dret = 1; cyc("R10"); idle;

    // R1 user ebreak without and with enable
    priv = 2'b00; ebm = 1; ebu = 0; ebreak = 1; pc = 32'h200; cyc("R1"); idle; cyc("R1");
    ebu = 1; ebreak = 1; cyc("R1"); idle; cyc("R6");
    dret = 1; cyc("R10"); idle; cyc("R6");

    // R2 halt edge, then held level
    priv = 2'b11; npc = 32'h300; halt = 1; cyc("R2"); cyc("R2");
    dret = 1; cyc("R2"); idle; cyc("R2"); cyc("R2");
    halt = 0; cyc("R2"); npc = 32'h340; halt = 1; cyc("R2"); halt = 0;
    dret = 1; cyc("R10"); idle;

    // R3 single step
    step = 1; retire = 1; npc = 32'h404; cyc("R3"); cyc("R3"); cyc("R3");
    retire = 0; dret = 1; cyc("R3"); idle; step = 0;

    // R4 priorities
    ebm = 1; ebreak = 1; halt = 1; step = 1; retire = 1; pc = 32'h500; npc = 32'h504;
    cyc("R4"); idle; halt = 0; dret = 1; cyc("R4"); idle; cyc("R4");
    halt = 1; retire = 1; npc = 32'h600; cyc("R4"); idle; step = 0; halt = 0;
    dret = 1; cyc("R4"); idle;

    // R9 sleep and wake
    wfi = 1; cyc("R9"); idle; cyc("R9"); cyc("R9");
    irq = 1; cyc("R9"); irq = 0; cyc("R9");
    wfi = 1; cyc("R9"); idle; cyc("R9");
    halt = 1; npc = 32'h700; cyc("R9"); cyc("R9"); halt = 0;
    dret = 1; cyc("R10"); idle; cyc("R11");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule